// File: doc/BRIEF.md
# Device Security State Filter

This block sits on the client path of an I/O memory management unit, between upstream requesters and the downstream memory side. Each transaction arrives with a device index and a security marking that the device chose itself. The filter does not trust that marking. It looks up the device index in a programmable bitmap and classifies the device as secure or non-secure. A non-secure device always leaves downstream marked non-secure. A secure device keeps the marking it sent.

The bitmap sits in 32-bit configuration registers. Register `k` holds devices `32k` to `32k+31`, with device N in register N/32 at bit N%32. A 2-bit capability input states whether this register space exists. When the space is absent, every device is treated as non-secure, so no default ever grants secure access. The filter is one valid/ready register stage. It raises a pulse whenever it strips a secure marking from a transaction that leaves the block.

Top module: `sec_filter`

## Requirements
- R1: Bitmap bit `cfg_wdata[N%32]` written to register address N/32 sets the class of device N: 1 means non-secure and 0 means secure. Reading that address returns the stored bits in the same positions.
- R2: A transaction from a device classed non-secure leaves with `dn_sec` = 0, whatever `up_sec` was.
- R3: A transaction from a device classed secure leaves with `dn_sec` equal to its `up_sec`.
- R4: The register space exists only when `space_cap` is 2'b01 or 2'b11. For 2'b00 or 2'b10, every device is non-secure, configuration writes are ignored and reads return 0. The stored bits are kept for when the space returns.
- R5: After reset, every implemented bitmap bit is 1, so every device is non-secure, and `dn_valid` is 0.
- R6: Writes to register addresses at or above ceil(NUM_DEV/32) are ignored and reads there return 0. Bits of the last register beyond NUM_DEV are not stored and read as 0.
- R7: A device index at or above NUM_DEV is treated as non-secure.
- R8: A transaction is accepted when `up_valid` and `up_ready` are both high, with `up_ready` = !`dn_valid` || `dn_ready`. It appears on the downstream side in the next cycle, with its device index, address and attributes unchanged.
- R9: While `dn_valid` is high and `dn_ready` is low, `dn_valid` and every downstream field stay stable.
- R10: `dn_downgrade` is high only in a cycle in which `dn_valid` and `dn_ready` are both high, and only when the transaction had `up_sec` = 1 and came from a non-secure device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| space_cap | input | 2 | Capability field stating whether the bitmap register space exists |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address (bitmap register index) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` (combinational) |
| up_valid | input | 1 | Upstream transaction valid |
| up_ready | output | 1 | Filter can accept a transaction |
| up_dev | input | 6 | Upstream device index |
| up_addr | input | 32 | Upstream address |
| up_attr | input | 4 | Upstream attributes |
| up_sec | input | 1 | Security marking claimed by the device |
| dn_valid | output | 1 | Downstream transaction valid |
| dn_ready | input | 1 | Downstream can take the transaction |
| dn_dev | output | 6 | Downstream device index |
| dn_addr | output | 32 | Downstream address |
| dn_attr | output | 4 | Downstream attributes |
| dn_sec | output | 1 | Corrected security marking |
| dn_downgrade | output | 1 | Pulse: a secure marking was stripped from the transaction now leaving |

## Verification
The assertions assume that `space_cap` changes only while no transaction is being accepted, and that configuration writes do not happen in the same cycle as an upstream acceptance. The bench drains the pipeline before it changes either one. They also assume that the upstream side holds its fields while a transaction waits for `up_ready`. The bench drives a transaction at the falling edge and keeps it until it sees `up_ready` high. Downstream back-pressure comes from a pseudo-random pattern, so stalls hit transactions of every security class.

// File: rtl/sec_filter_pkg.sv
package sec_filter_pkg;

    localparam int SF_DEV_W   = 6;
    localparam int SF_ADDR_W  = 32;
    localparam int SF_ATTR_W  = 4;
    localparam int SF_CFG_AW  = 4;
    localparam int SF_WORD_W  = 32;
    localparam int SF_NUM_DEV = 40;

    typedef struct packed {
        logic [SF_DEV_W-1:0]  dev;
        logic [SF_ADDR_W-1:0] addr;
        logic [SF_ATTR_W-1:0] attr;
        logic                 sec;
        logic                 dg;
    } sf_txn_t;

    // Capability codes 01 and 11 mean the bitmap register space exists.
    function automatic logic sf_space_on(input logic [1:0] cap);
        return cap[0];
    endfunction

    function automatic int sf_num_regs(input int num_dev);
        return (num_dev + SF_WORD_W - 1) / SF_WORD_W;
    endfunction

endpackage

// File: rtl/sec_bitmap.sv
module sec_bitmap
    import sec_filter_pkg::*;
#(
    parameter int NUM_DEV = SF_NUM_DEV
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 space_on,
    input  logic                 cfg_wr,
    input  logic [SF_CFG_AW-1:0] cfg_addr,
    input  logic [SF_WORD_W-1:0] cfg_wdata,
    output logic [SF_WORD_W-1:0] cfg_rdata,
    input  logic [SF_DEV_W-1:0]  lk_dev,
    output logic                 lk_ns
);

    localparam int NUM_REGS = sf_num_regs(NUM_DEV);

    logic [NUM_DEV-1:0]   map_q;
    logic [NUM_REGS-1:0]  wr_hit;
    logic [SF_WORD_W-1:0] words [NUM_REGS];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        assign wr_hit[k] = space_on && cfg_wr && (cfg_addr == SF_CFG_AW'(k));
        for (genvar b = 0; b < SF_WORD_W; b++) begin : g_bit
            if (k * SF_WORD_W + b < NUM_DEV) begin : g_impl
                always_ff @(posedge clk) begin
                    if (rst) begin
                        map_q[k*SF_WORD_W+b] <= 1'b1;
                    end else if (wr_hit[k]) begin
                        map_q[k*SF_WORD_W+b] <= cfg_wdata[b];
                    end
                end
                assign words[k][b] = map_q[k*SF_WORD_W+b];
            end else begin : g_none
                assign words[k][b] = 1'b0;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (space_on && cfg_addr == SF_CFG_AW'(k)) begin
                cfg_rdata = words[k];
            end
        end
    end

    always_comb begin
        lk_ns = 1'b1;
        for (int j = 0; j < NUM_DEV; j++) begin
            if (space_on && lk_dev == SF_DEV_W'(j)) begin
                lk_ns = map_q[j];
            end
        end
    end

endmodule

// File: rtl/sec_decide.sv
module sec_decide (
    input  logic claimed_sec,
    input  logic dev_ns,
    output logic out_sec,
    output logic downgrade
);

    always_comb begin
        out_sec   = claimed_sec && !dev_ns;
        downgrade = claimed_sec && dev_ns;
    end

endmodule

// File: rtl/sec_stage.sv
module sec_stage
    import sec_filter_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    output logic    in_ready,
    input  sf_txn_t in_txn,
    output logic    out_valid,
    input  logic    out_ready,
    output sf_txn_t out_txn
);

    logic    valid_q;
    sf_txn_t txn_q;

    assign in_ready  = !valid_q || out_ready;
    assign out_valid = valid_q;
    assign out_txn   = txn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            txn_q   <= '0;
        end else if (in_ready) begin
            valid_q <= in_valid;
            if (in_valid) begin
                txn_q <= in_txn;
            end
        end
    end

endmodule

// File: rtl/sec_filter.sv
module sec_filter
    import sec_filter_pkg::*;
#(
    parameter int NUM_DEV = SF_NUM_DEV
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           space_cap,
    input  logic                 cfg_wr,
    input  logic [SF_CFG_AW-1:0] cfg_addr,
    input  logic [SF_WORD_W-1:0] cfg_wdata,
    output logic [SF_WORD_W-1:0] cfg_rdata,
    input  logic                 up_valid,
    output logic                 up_ready,
    input  logic [SF_DEV_W-1:0]  up_dev,
    input  logic [SF_ADDR_W-1:0] up_addr,
    input  logic [SF_ATTR_W-1:0] up_attr,
    input  logic                 up_sec,
    output logic                 dn_valid,
    input  logic                 dn_ready,
    output logic [SF_DEV_W-1:0]  dn_dev,
    output logic [SF_ADDR_W-1:0] dn_addr,
    output logic [SF_ATTR_W-1:0] dn_attr,
    output logic                 dn_sec,
    output logic                 dn_downgrade
);

    logic    space_on;
    logic    dev_ns;
    logic    fixed_sec;
    logic    strip;
    sf_txn_t in_txn;
    sf_txn_t out_txn;

    assign space_on = sf_space_on(space_cap);

    sec_bitmap #(.NUM_DEV(NUM_DEV)) u_map (
        .clk      (clk),
        .rst      (rst),
        .space_on (space_on),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .lk_dev   (up_dev),
        .lk_ns    (dev_ns)
    );

    sec_decide u_dec (
        .claimed_sec(up_sec),
        .dev_ns     (dev_ns),
        .out_sec    (fixed_sec),
        .downgrade  (strip)
    );

    always_comb begin
        in_txn.dev  = up_dev;
        in_txn.addr = up_addr;
        in_txn.attr = up_attr;
        in_txn.sec  = fixed_sec;
        in_txn.dg   = strip;
    end

    sec_stage u_stage (
        .clk      (clk),
        .rst      (rst),
        .in_valid (up_valid),
        .in_ready (up_ready),
        .in_txn   (in_txn),
        .out_valid(dn_valid),
        .out_ready(dn_ready),
        .out_txn  (out_txn)
    );

    assign dn_dev       = out_txn.dev;
    assign dn_addr      = out_txn.addr;
    assign dn_attr      = out_txn.attr;
    assign dn_sec       = out_txn.sec;
    assign dn_downgrade = dn_valid && dn_ready && out_txn.dg;

endmodule

// File: rtl/sec_filter_chk.sv
module sec_filter_chk
    import sec_filter_pkg::*;
#(
    parameter int NUM_DEV = SF_NUM_DEV
) (
    input logic                 clk,
    input logic                 rst,
    input logic [1:0]           space_cap,
    input logic [SF_WORD_W-1:0] cfg_rdata,
    input logic                 up_valid,
    input logic                 up_ready,
    input logic [SF_DEV_W-1:0]  up_dev,
    input logic                 up_sec,
    input logic                 dn_valid,
    input logic                 dn_ready,
    input logic [SF_DEV_W-1:0]  dn_dev,
    input logic [SF_ADDR_W-1:0] dn_addr,
    input logic [SF_ATTR_W-1:0] dn_attr,
    input logic                 dn_sec,
    input logic                 dn_downgrade
);

    // R9: stalled output holds
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_dev) && $stable(dn_addr)
            && $stable(dn_attr) && $stable(dn_sec));

    // R10: flag only on an accepted, non-secure result
    a_r10_flag_on_accept: assert property (@(posedge clk) disable iff (rst)
        dn_downgrade |-> dn_valid && dn_ready && !dn_sec);

    // R8: accepted transaction shows up next cycle
    a_r8_one_stage: assert property (@(posedge clk) disable iff (rst)
        up_valid && up_ready |=> dn_valid);

    // R2: a non-secure claim never becomes secure
    a_r2_no_upgrade: assert property (@(posedge clk) disable iff (rst)
        up_valid && up_ready && !up_sec |=> !dn_sec);

    // R7: out-of-range device never secure
    a_r7_range_ns: assert property (@(posedge clk) disable iff (rst)
        up_valid && up_ready && int'(up_dev) >= NUM_DEV |=> !dn_sec);

    // R4: absent space gives non-secure results
    a_r4_absent_ns: assert property (@(posedge clk) disable iff (rst)
        up_valid && up_ready && !sf_space_on(space_cap) |=> !dn_sec);

    // R4: absent space reads zero
    a_r4_absent_read: assert property (@(posedge clk) disable iff (rst)
        !sf_space_on(space_cap) |-> cfg_rdata == '0);

endmodule

bind sec_filter sec_filter_chk #(.NUM_DEV(NUM_DEV)) u_chk (.*);

// File: tb/sec_filter_tb.sv
module sec_filter_tb;
    import sec_filter_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_DEV    = SF_NUM_DEV;
    localparam int NUM_REGS   = (NUM_DEV + 31) / 32;

    logic                 clk = 0;
    logic                 rst = 1;
    logic [1:0]           space_cap = 2'b01;
    logic                 cfg_wr = 0;
    logic [SF_CFG_AW-1:0] cfg_addr = '0;
    logic [SF_WORD_W-1:0] cfg_wdata = '0;
    logic [SF_WORD_W-1:0] cfg_rdata;
    logic                 up_valid = 0;
    logic                 up_ready;
    logic [SF_DEV_W-1:0]  up_dev = '0;
    logic [SF_ADDR_W-1:0] up_addr = '0;
    logic [SF_ATTR_W-1:0] up_attr = '0;
    logic                 up_sec = 0;
    logic                 dn_valid;
    logic                 dn_ready = 1;
    logic [SF_DEV_W-1:0]  dn_dev;
    logic [SF_ADDR_W-1:0] dn_addr;
    logic [SF_ATTR_W-1:0] dn_attr;
    logic                 dn_sec;
    logic                 dn_downgrade;

    sec_filter u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    sf_txn_t exp_q [$];
    string   tag_q [$];
    logic    shadow [NUM_DEV];
    bit      stall_en = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_ns(input int dev);
        if (!space_cap[0]) return 1;
        if (dev >= NUM_DEV) return 1;
        return shadow[dev];
    endfunction

    // downstream back-pressure
    always @(negedge clk) begin
        lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        dn_ready <= stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // monitor / scoreboard
    bit      prev_stall = 0;
    sf_txn_t held;
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (prev_stall) begin
                check(dn_valid && dn_dev == held.dev && dn_addr == held.addr &&
                      dn_attr == held.attr && dn_sec == held.sec, "R9",
                      {dn_dev, dn_addr}, {held.dev, held.addr});
            end
            prev_stall = dn_valid && !dn_ready;
            held.dev = dn_dev; held.addr = dn_addr; held.attr = dn_attr;
            held.sec = dn_sec; held.dg = 1'b0;
            if (dn_valid && dn_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8", 1, 0);
                end else begin
                    sf_txn_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(dn_dev == e.dev && dn_addr == e.addr && dn_attr == e.attr,
                          "R8", {dn_dev, dn_addr}, {e.dev, e.addr});
                    check(dn_sec == e.sec, t, dn_sec, e.sec);
                    check(dn_downgrade == e.dg, "R10", dn_downgrade, e.dg);
                end
            end else begin
                check(dn_downgrade == 0, "R10", dn_downgrade, 0);
            end
        end
    end

    task automatic send(input int dev, input logic [31:0] addr, input logic [3:0] attr,
                        input bit sec);
        sf_txn_t e;
        bit ns;
        @(negedge clk);
        up_valid = 1; up_dev = SF_DEV_W'(dev); up_addr = addr; up_attr = attr; up_sec = sec;
        #1;
        while (!up_ready) begin
            @(negedge clk);
            #1;
        end
        ns = exp_ns(dev);
        e.dev = SF_DEV_W'(dev); e.addr = addr; e.attr = attr;
        e.sec = sec && !ns; e.dg = sec && ns;
        exp_q.push_back(e);
        if (!space_cap[0])       tag_q.push_back("R4");
        else if (dev >= NUM_DEV) tag_q.push_back("R7");
        else if (ns)             tag_q.push_back("R2");
        else                     tag_q.push_back("R3");
        @(posedge clk);
    endtask

    task automatic idle_drain();
        @(negedge clk);
        up_valid = 0;
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R8", exp_q.size(), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic cfg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = SF_CFG_AW'(a); cfg_wdata = d;
        if (space_cap[0] && a < NUM_REGS) begin
            for (int b = 0; b < 32; b++)
                if (a * 32 + b < NUM_DEV) shadow[a*32+b] = d[b];
        end
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic cfg_check(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = SF_CFG_AW'(a);
        #1;
        check(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NUM_DEV; i++) shadow[i] = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check(dn_valid == 0, "R5", dn_valid, 0);
        check(up_ready == 1, "R8", up_ready, 1);
        cfg_check(0, 32'hFFFF_FFFF, "R5");
        cfg_check(1, 32'h0000_00FF, "R6");
        cfg_check(2, 32'h0, "R6");

        // reset state: everything downgraded
        for (int d = 0; d < 8; d++) send(d * 5, 32'h1000 + d, 4'(d), 1);
        idle_drain();

        // programming
        cfg_write(0, 32'h0000_00F0);
        cfg_check(0, 32'h0000_00F0, "R1");
        cfg_write(1, 32'hFFFF_FF05);
        cfg_check(1, 32'h0000_0005, "R6");
        cfg_write(3, 32'h0000_1234);
        cfg_check(3, 32'h0, "R6");
        cfg_check(0, 32'h0000_00F0, "R6");

        // sweep all indices, both claims, with back-pressure
        stall_en = 1;
        for (int d = 0; d < 64; d++) begin
            send(d, 32'hA000_0000 + 32'(d * 4), 4'(d), 1);
            send(d, 32'hB000_0000 + 32'(d * 4), 4'(~d), 0);
        end
        idle_drain();
        stall_en = 0;

        // new pattern in register 1
        cfg_write(1, 32'h0000_00AA);
        cfg_check(1, 32'h0000_00AA, "R1");
        for (int d = 32; d < 40; d++) send(d, 32'hC000_0000 + 32'(d), 4'h3, 1);
        idle_drain();

        // absent register space, both absent codes
        for (int c = 0; c < 2; c++) begin
            space_cap = (c == 0) ? 2'b10 : 2'b00;
            cfg_check(0, 32'h0, "R4");
            cfg_write(0, 32'h0000_0000);
            stall_en = 1;
            for (int d = 0; d < 8; d++) send(d, 32'hD000_0000 + 32'(d), 4'h1, 1);
            idle_drain();
            stall_en = 0;
        end
        space_cap = 2'b11;
        cfg_check(0, 32'h0000_00F0, "R4");
        for (int d = 0; d < 8; d++) send(d, 32'hE000_0000 + 32'(d), 4'h2, 1);
        idle_drain();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule